// File: doc/BRIEF.md
# Packet Latency Guard

This block sits in a network interface between the router and the local endpoint. A free-running 16-bit cycle counter supplies the time base. Every header leaving the interface has its timestamp field overwritten with the current count in the same cycle, so the sender's clock value travels with the packet.

When a header arrives, the block subtracts the carried timestamp from the local count. The unsigned 16-bit difference stays correct across counter wrap-around. The result is compared with a limit that software programs, and the header is always reported as accepted.

When the elapsed time is strictly above the limit, the block queues a one-word alarm naming the sender and the receiver. The alarm goes to a management queue over a valid/ready output. A small queue absorbs back-pressure on that output, so the receive path never waits on it. An alarm for a pair that is already waiting is discarded, as is an alarm that finds the queue full. Each discarded alarm is counted.

Top module: `pkt_latency_guard`

## Requirements
- R1: The header is 32 bits: sender id in bits 31:24, receiver id in bits 23:16, timestamp in bits 15:0. The outgoing header equals the incoming transmit header with bits 15:0 replaced by the time counter, combinationally in the same cycle.
- R2: The time counter reads 0 in the first cycle after reset is released, increments by one each cycle, and wraps from 65535 to 0.
- R3: The outgoing transmit valid equals the incoming transmit valid in the same cycle.
- R4: One cycle after a receive header is presented, the reported latency equals (counter − timestamp) modulo 65536, sampled in the presentation cycle, including when the timestamp is numerically larger than the counter.
- R5: The late flag is set exactly when the latency is strictly greater than the limit input; a latency equal to the limit is not late.
- R6: Every receive header produces an accept pulse exactly one cycle later, whether or not the alarm output is blocked.
- R7: A late header whose pair is not already queued, arriving while the queue has room, appears on the alarm output one cycle later if the queue was empty. The alarm carries the header's sender and receiver ids.
- R8: A late header whose pair matches an alarm still waiting in the queue is discarded, and the drop counter increases by one.
- R9: A late header that finds the queue full (4 entries by default) is discarded, and the drop counter increases by one.
- R10: Alarms leave in arrival order, one per cycle with valid and ready both high. While valid is high and ready is low, the alarm word holds steady.
- R11: During and just after reset, accept, late and alarm valid are low, and the drop counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_valid | input | 1 | Transmit header present |
| tx_in_hdr | input | 32 | Transmit header before stamping |
| tx_out_valid | output | 1 | Stamped header present |
| tx_out_hdr | output | 32 | Header with timestamp inserted |
| rx_valid | input | 1 | Receive header present |
| rx_hdr | input | 32 | Received header |
| limit | input | 16 | Latency limit in cycles |
| rx_done | output | 1 | Header accepted (one cycle after arrival) |
| rx_latency | output | 16 | Measured latency of the accepted header |
| rx_late | output | 1 | Latency exceeded the limit |
| alarm_valid | output | 1 | Alarm word available |
| alarm_ready | input | 1 | Management queue takes the alarm |
| alarm_src | output | 8 | Sender id of the late packet |
| alarm_dst | output | 8 | Receiver id of the late packet |
| drop_count | output | 16 | Number of discarded alarms (wraps) |

## Verification
A wrong time counter appears on the very next stamped header. It also skews every measured latency by the same offset one cycle after arrival. A queue pointer or occupancy error appears as an alarm word that changes while the output is blocked, or that leaves out of order. It can also show as a drop counter that moves when it should not, visible within a cycle of the offending arrival. Duplicate detection is exercised against a blocked output, so a stale or missed match changes the drop count directly.

// File: rtl/lat_pkg.sv
package lat_pkg;
    localparam int TS_W  = 16;
    localparam int ID_W  = 8;
    localparam int HDR_W = 2 * ID_W + TS_W;

    typedef struct packed {
        logic [ID_W-1:0] src;
        logic [ID_W-1:0] dst;
        logic [TS_W-1:0] stamp;
    } hdr_t;

    typedef struct packed {
        logic [ID_W-1:0] src;
        logic [ID_W-1:0] dst;
    } pair_t;

    function automatic logic [TS_W-1:0] elapsed(input logic [TS_W-1:0] now,
                                                input logic [TS_W-1:0] sent);
        return now - sent;
    endfunction
endpackage

// File: rtl/lat_time_base.sv
module lat_time_base #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> now == W'($past(now) + 1'b1));
endmodule

// File: rtl/lat_rx_meter.sv
module lat_rx_meter
    import lat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [TS_W-1:0] now,
    input  logic            rx_valid,
    input  hdr_t            rx_hdr,
    input  logic [TS_W-1:0] limit,
    output logic            done,
    output logic [TS_W-1:0] latency,
    output logic            late,
    output logic            alarm_req,
    output pair_t           alarm_pair
);
    logic [TS_W-1:0] lat_now;
    logic            over;

    always_comb begin
        lat_now    = elapsed(now, rx_hdr.stamp);
        over       = lat_now > limit;
        alarm_req  = rx_valid && over;
        alarm_pair = '{src: rx_hdr.src, dst: rx_hdr.dst};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            latency <= '0;
            late    <= 1'b0;
        end else begin
            done    <= rx_valid;
            latency <= rx_valid ? lat_now : latency;
            late    <= rx_valid && over;
        end
    end

    // R6
    accept_always_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> done);
    // R5
    late_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        late |-> done);
endmodule

// File: rtl/lat_alarm_queue.sv
module lat_alarm_queue
    import lat_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  pair_t             push_pair,
    input  logic              out_ready,
    output logic              out_valid,
    output pair_t             out_pair,
    output logic [DROP_W-1:0] drops
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    pair_t            mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic [DEPTH-1:0] hit;
    logic             dup, full, take, lose, pop;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [PTR_W-1:0] off;
        assign off    = PTR_W'(i) - rd_ptr;
        assign hit[i] = ({1'b0, off} < count) && (mem[i] == push_pair);
    end

    always_comb begin
        dup       = |hit;
        full      = count == CNT_W'(DEPTH);
        take      = push && !dup && !full;
        lose      = push && (dup || full);
        out_valid = count != '0;
        out_pair  = mem[rd_ptr];
        pop       = out_valid && out_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            drops  <= '0;
        end else begin
            if (take) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(take) - CNT_W'(pop);
            if (lose) drops <= drops + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) mem[wr_ptr] <= push_pair;
    end

    // R9
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    // R10
    hold_when_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pair));
    // R8
    drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && drops != $past(drops) |-> $past(push));
endmodule

// File: rtl/pkt_latency_guard.sv
module pkt_latency_guard
    import lat_pkg::*;
#(
    parameter int ALM_DEPTH = 4,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_in_valid,
    input  logic [HDR_W-1:0]  tx_in_hdr,
    output logic              tx_out_valid,
    output logic [HDR_W-1:0]  tx_out_hdr,
    input  logic              rx_valid,
    input  logic [HDR_W-1:0]  rx_hdr,
    input  logic [TS_W-1:0]   limit,
    output logic              rx_done,
    output logic [TS_W-1:0]   rx_latency,
    output logic              rx_late,
    output logic              alarm_valid,
    input  logic              alarm_ready,
    output logic [ID_W-1:0]   alarm_src,
    output logic [ID_W-1:0]   alarm_dst,
    output logic [DROP_W-1:0] drop_count
);
    logic [TS_W-1:0] now;
    hdr_t            tx_h, rx_h, tx_o;
    logic            req;
    pair_t           req_pair, head;

    lat_time_base #(.W(TS_W)) u_time (.clk(clk), .rst(rst), .now(now));

    always_comb begin
        tx_h         = hdr_t'(tx_in_hdr);
        tx_o         = tx_h;
        tx_o.stamp   = now;
        tx_out_hdr   = tx_o;
        tx_out_valid = tx_in_valid;
        rx_h         = hdr_t'(rx_hdr);
        alarm_src    = head.src;
        alarm_dst    = head.dst;
    end

    lat_rx_meter u_meter (
        .clk(clk), .rst(rst), .now(now), .rx_valid(rx_valid), .rx_hdr(rx_h),
        .limit(limit), .done(rx_done), .latency(rx_latency), .late(rx_late),
        .alarm_req(req), .alarm_pair(req_pair)
    );

    lat_alarm_queue #(.DEPTH(ALM_DEPTH), .DROP_W(DROP_W)) u_queue (
        .clk(clk), .rst(rst), .push(req), .push_pair(req_pair),
        .out_ready(alarm_ready), .out_valid(alarm_valid), .out_pair(head),
        .drops(drop_count)
    );

    // R7
    alarm_follows_late_chk: assert property (@(posedge clk) disable iff (rst)
        rx_late |-> alarm_valid);
endmodule

// File: tb/tb_pkt_latency_guard.sv
module tb_pkt_latency_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_in_valid = 1'b0;
    logic [31:0] tx_in_hdr = '0;
    logic        tx_out_valid;
    logic [31:0] tx_out_hdr;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_hdr = '0;
    logic [15:0] limit = '0;
    logic        rx_done, rx_late, alarm_valid;
    logic        alarm_ready = 1'b1;
    logic [15:0] rx_latency, drop_count;
    logic [7:0]  alarm_src, alarm_dst;

    int tb_cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;
    always @(posedge clk) tb_cyc <= rst ? 0 : tb_cyc + 1;

    pkt_latency_guard dut (.*);

    // src, dst, latency, limit, expected late
    localparam int NV = 8;
    localparam int VEC [NV][5] = '{
        '{1, 2, 3, 10, 0}, '{3, 4, 10, 10, 0}, '{5, 6, 11, 10, 1},
        '{7, 8, 0, 0, 0}, '{9, 10, 1, 0, 1}, '{11, 12, 900, 100, 1},
        '{13, 14, 65535, 65534, 1}, '{15, 16, 200, 65535, 0}};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_rx(input int s, input int d, input int lat);
        rx_hdr   = {8'(s), 8'(d), 16'(tb_cyc - lat)};
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11
        chk(!rx_done && !rx_late && !alarm_valid, "R11", rx_done, 0);
        chk(drop_count == 0, "R11", drop_count, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_out_hdr[15:0] == 16'd1, "R2", tx_out_hdr[15:0], 1);
        chk(!alarm_valid && drop_count == 0, "R11", drop_count, 0);

        for (int k = 0; k < NV; k++) begin
            tx_in_valid = k[0];
            tx_in_hdr   = {8'(VEC[k][0] + 100), 8'(VEC[k][1] + 100), 16'hdead};
            #1;
            // R1 R3
            chk(tx_out_hdr == {8'(VEC[k][0] + 100), 8'(VEC[k][1] + 100), 16'(tb_cyc)},
                "R1", tx_out_hdr, {8'(VEC[k][0] + 100), 8'(VEC[k][1] + 100), 16'(tb_cyc)});
            chk(tx_out_valid == k[0], "R3", tx_out_valid, k[0]);
            limit = 16'(VEC[k][3]);
            send_rx(VEC[k][0], VEC[k][1], VEC[k][2]);
            chk(rx_done, "R6", rx_done, 1);
            chk(rx_latency == 16'(VEC[k][2]), "R4", rx_latency, 16'(VEC[k][2]));
            chk(rx_late == VEC[k][4][0], "R5", rx_late, VEC[k][4]);
            if (VEC[k][4] != 0)
                chk(alarm_valid && alarm_src == 8'(VEC[k][0]) && alarm_dst == 8'(VEC[k][1]),
                    "R7", {alarm_src, alarm_dst}, {8'(VEC[k][0]), 8'(VEC[k][1])});
            else
                chk(!alarm_valid, "R7", alarm_valid, 0);
        end

        // blocked output: duplicates and full queue
        @(negedge clk);
        alarm_ready = 1'b0;
        limit = 16'd5;
        send_rx(20, 21, 50);
        send_rx(20, 21, 60);
        chk(rx_done, "R6", rx_done, 1);
        send_rx(20, 21, 70);
        chk(drop_count == 2, "R8", drop_count, 2);
        send_rx(22, 23, 50);
        send_rx(24, 25, 50);
        send_rx(26, 27, 50);
        chk(drop_count == 2, "R7", drop_count, 2);
        send_rx(28, 29, 50);
        chk(drop_count == 3, "R9", drop_count, 3);
        send_rx(24, 25, 50);
        chk(drop_count == 4, "R8", drop_count, 4);
        chk(alarm_valid && alarm_src == 8'd20, "R10", alarm_src, 20);
        alarm_ready = 1'b1;
        #1;
        chk(alarm_src == 8'd20 && alarm_dst == 8'd21, "R10", alarm_src, 20);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(alarm_valid && alarm_src == 8'(22 + 2 * j), "R10", alarm_src, 22 + 2 * j);
        end
        @(negedge clk);
        chk(!alarm_valid, "R10", alarm_valid, 0);
        limit = 16'd0;
        send_rx(40, 41, 0);
        chk(!rx_late && drop_count == 4, "R5", rx_late, 0);

        // counter wrap
        while (tb_cyc != 65535) @(negedge clk);
        #1;
        chk(tx_out_hdr[15:0] == 16'hffff, "R2", tx_out_hdr[15:0], 65535);
        @(negedge clk);
        chk(tx_out_hdr[15:0] == 16'h0000, "R2", tx_out_hdr[15:0], 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule